// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps calendar time in packed BCD inside a larger chip. A prescaler divides an oscillator tick input down to a sub-second step. A sub-second counter advances on each step, and its wrap carries into a cascade of seconds, minutes, hours, day of week, day of month, month and a four-digit year. Software sees every field as a 16-bit register on a simple single-cycle register port. A write takes effect at the next clock edge and a read is combinational. The port applies no back-pressure and has no handshake.

Counting is controlled from a control register, which sets the run and enable bits. The same register also clears the prescaler and rounds the time to the nearest minute. Software is meant to read the time as follows:

1. Clear the sticky carry flag.
2. Read the time fields.
3. Check the flag again, and repeat the read if a seconds increment happened during it.

The carry flag can also raise an interrupt when it is enabled.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the registers read: sub-second 0, seconds 0x00, minutes 0x00, hours 0x00, weekday 0, day of month 0x01, month 0x01, year 0x2000, both control registers 0x0000; carry_irq is low.
- R2: Register word indices are 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year (century BCD in bits 15:8, low two digits in bits 7:0), 14 status/carry control, 15 run control. Time fields 1 to 7 load directly from a write while the run bit is 0 and read back unchanged; index 0 is read-only.
- R3: While the run bit (index 15 bit 0) is 1, writes to indices 1 to 7 leave the fields unchanged.
- R4: Counting happens only when both the run bit (bit 0) and enable bit (bit 3) of index 15 are 1; the sub-second counter then steps once per PRE_DIV oscillator ticks and wraps after SUB_STEPS steps, carrying into the seconds.
- R5: Seconds and minutes roll over 0x59 to 0x00 and hours 0x23 to 0x00, each rollover advancing the next field.
- R6: Weekday counts 0 to 6 and returns to 0, advancing at each hour rollover from 0x23.
- R7: Day of month returns to 0x01 after the month's last day (0x30 for months 4, 6, 9, 11, else 0x31), month rolls 0x12 to 0x01, and the year advances as four BCD digits including the century digits.
- R8: February ends at 0x29 when the two low year digits form a number divisible by 4, otherwise at 0x28.
- R9: The carry flag (index 14 bit 7) sets on every seconds increment and on each adjustment, stays set until a write to index 14 with bit 7 at 0, ignores a write of 1, and a set wins over a clear in the same cycle.
- R10: carry_irq is high exactly when the carry flag and the carry interrupt enable (index 14 bit 4) are both 1.
- R11: Writing index 15 with bit 1 set clears the prescaler and the sub-second counter; that bit reads back 0 and the run and enable bits take the written values.
- R12: Writing index 15 with bit 2 set rounds the time: seconds below 0x30 become 0x00, seconds 0x30 or above become 0x00 with a minute increment that cascades; the prescaler and sub-second counter clear and the bit reads back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
Some properties hold on every cycle and are checked that way:
- a seconds increment always leaves the carry flag set;
- the flag survives every cycle without a clearing write;
- 0x59 seconds always lead to 0x00;
- the prescaler clear and the adjustment always leave the sub-second counter at zero;
- a stopped counter holds its seconds.

Other behaviours need stimulus to reach them, and only the bench scenarios show them:
- the full calendar cascade into a new century;
- month lengths and leap Februaries;
- blocking of time writes while running;
- the exact sub-second step rate;
- the rounding direction of the adjustment.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned YEAR_DIGITS = 4;
  localparam int unsigned YEAR_W  = 4 * YEAR_DIGITS;

  localparam logic [ADDR_W-1:0] A_SUB  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR = 4'd3;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'd4;
  localparam logic [ADDR_W-1:0] A_MDAY = 4'd5;
  localparam logic [ADDR_W-1:0] A_MON  = 4'd6;
  localparam logic [ADDR_W-1:0] A_YEAR = 4'd7;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd14;
  localparam logic [ADDR_W-1:0] A_RUN  = 4'd15;

  localparam int unsigned CF_BIT    = 7;
  localparam int unsigned CIE_BIT   = 4;
  localparam int unsigned GO_BIT    = 0;
  localparam int unsigned PRST_BIT  = 1;
  localparam int unsigned ROUND_BIT = 2;
  localparam int unsigned EN_BIT    = 3;

  typedef struct packed {
    logic [FIELD_W-1:0] sec;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] wday;
    logic [FIELD_W-1:0] mday;
    logic [FIELD_W-1:0] mon;
    logic [YEAR_W-1:0]  year;
  } cal_t;

  localparam cal_t CAL_INIT = '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h00,
                                mday: 8'h01, mon: 8'h01, year: 16'h2000};

  // two-digit BCD increment, no wrap handling
  function automatic logic [FIELD_W-1:0] bcd2_inc(input logic [FIELD_W-1:0] v);
    logic [FIELD_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // multi-digit BCD increment with ripple carry through all digits
  function automatic logic [YEAR_W-1:0] bcdn_inc(input logic [YEAR_W-1:0] v);
    logic [YEAR_W-1:0] r;
    logic c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < YEAR_DIGITS; i++) begin
      if (c) begin
        if (r[4*i +: 4] >= 4'd9) r[4*i +: 4] = 4'd0;
        else begin
          r[4*i +: 4] = r[4*i +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic year_is_leap(input logic [7:0] low2);
    logic [6:0] b;
    b = 7'(low2[7:4]) * 7'd10 + 7'(low2[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [FIELD_W-1:0] last_day(input logic [FIELD_W-1:0] m, input logic leap);
    logic [FIELD_W-1:0] r;
    case (m)
      8'h02: r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default: r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned PRE_DIV   = 256,
  parameter int unsigned SUB_STEPS = 128,
  localparam int unsigned SUB_W    = (SUB_STEPS > 1) ? $clog2(SUB_STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             osc_tick,
  input  logic             clr,
  output logic [SUB_W-1:0] subsec,
  output logic             sec_tick
);
  logic step;

  generate
    if (PRE_DIV <= 1) begin : g_nodiv
      assign step = run & osc_tick & ~clr;
    end else begin : g_div
      localparam int unsigned PRE_W = $clog2(PRE_DIV);
      logic [PRE_W-1:0] pre_q;
      logic             pre_last;
      assign pre_last = (pre_q == PRE_W'(PRE_DIV - 1));
      assign step     = run & osc_tick & ~clr & pre_last;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pre_q <= '0;
        else if (clr)             pre_q <= '0;
        else if (run && osc_tick) pre_q <= pre_last ? '0 : pre_q + 1'b1;
      end
    end
  endgenerate

  logic sub_last;
  assign sub_last = (subsec == SUB_W'(SUB_STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    subsec <= '0;
    else if (clr)  subsec <= '0;
    else if (step) subsec <= sub_last ? '0 : subsec + 1'b1;
  end

  assign sec_tick = step & sub_last;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              round_req,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  output cal_t              cal
);
  cal_t nxt;
  logic min_step, hour_step, day_step, mon_step, yr_step;
  logic [FIELD_W-1:0] mlast;

  assign mlast = last_day(cal.mon, year_is_leap(cal.year[7:0]));

  always_comb begin
    nxt      = cal;
    min_step = 1'b0;
    if (round_req) begin
      nxt.sec  = 8'h00;
      min_step = (cal.sec >= 8'h30);
    end else if (sec_tick) begin
      if (cal.sec >= 8'h59) begin
        nxt.sec  = 8'h00;
        min_step = 1'b1;
      end else begin
        nxt.sec = bcd2_inc(cal.sec);
      end
    end

    hour_step = min_step & (cal.min >= 8'h59);
    if (min_step) nxt.min = (cal.min >= 8'h59) ? 8'h00 : bcd2_inc(cal.min);

    day_step = hour_step & (cal.hour >= 8'h23);
    if (hour_step) nxt.hour = (cal.hour >= 8'h23) ? 8'h00 : bcd2_inc(cal.hour);

    mon_step = day_step & (cal.mday >= mlast);
    if (day_step) begin
      nxt.wday = (cal.wday >= 8'h06) ? 8'h00 : cal.wday + 8'd1;
      nxt.mday = (cal.mday >= mlast) ? 8'h01 : bcd2_inc(cal.mday);
    end

    yr_step = mon_step & (cal.mon >= 8'h12);
    if (mon_step) nxt.mon = (cal.mon >= 8'h12) ? 8'h01 : bcd2_inc(cal.mon);

    if (yr_step) nxt.year = bcdn_inc(cal.year);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal <= CAL_INIT;
    end else if (ld_en) begin
      case (ld_idx)
        A_SEC:   cal.sec  <= ld_data[FIELD_W-1:0];
        A_MIN:   cal.min  <= ld_data[FIELD_W-1:0];
        A_HOUR:  cal.hour <= ld_data[FIELD_W-1:0];
        A_WDAY:  cal.wday <= ld_data[FIELD_W-1:0];
        A_MDAY:  cal.mday <= ld_data[FIELD_W-1:0];
        A_MON:   cal.mon  <= ld_data[FIELD_W-1:0];
        A_YEAR:  cal.year <= ld_data[YEAR_W-1:0];
        default: ;
      endcase
    end else begin
      cal <= nxt;
    end
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stat,
  input  logic       wr_run,
  input  logic [7:0] wdata,
  input  logic       sec_tick,
  output logic       go,
  output logic       en,
  output logic       cf,
  output logic       cie,
  output logic       clr_pre,
  output logic       round_req
);
  logic cf_set;

  assign round_req = wr_run & wdata[ROUND_BIT];
  assign clr_pre   = wr_run & (wdata[PRST_BIT] | wdata[ROUND_BIT]);
  assign cf_set    = sec_tick | round_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0;
      en <= 1'b0;
    end else if (wr_run) begin
      go <= wdata[GO_BIT];
      en <= wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cie <= 1'b0;
    else if (wr_stat) cie <= wdata[CIE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cf <= 1'b0;
    else if (cf_set)                      cf <= 1'b1;
    else if (wr_stat && !wdata[CF_BIT])   cf <= 1'b0;
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRE_DIV   = 256,
  parameter int unsigned SUB_STEPS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              carry_irq
);
  localparam int unsigned SUB_W = (SUB_STEPS > 1) ? $clog2(SUB_STEPS) : 1;

  logic             wr, wr_stat, wr_run, ld_en;
  logic             go, en, run, cf, cie, clr_pre, round_req, sec_tick;
  logic [SUB_W-1:0] subsec;
  cal_t             cal;

  assign wr      = bus_sel & bus_wr;
  assign wr_stat = wr & (bus_addr == A_STAT);
  assign wr_run  = wr & (bus_addr == A_RUN);
  assign ld_en   = wr & ~go & (bus_addr >= A_SEC) & (bus_addr <= A_YEAR);
  assign run     = go & en;

  rtc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_run(wr_run),
    .wdata(bus_wdata[7:0]), .sec_tick(sec_tick), .go(go), .en(en),
    .cf(cf), .cie(cie), .clr_pre(clr_pre), .round_req(round_req)
  );

  rtc_prescaler #(.PRE_DIV(PRE_DIV), .SUB_STEPS(SUB_STEPS)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .osc_tick(osc_tick),
    .clr(clr_pre), .subsec(subsec), .sec_tick(sec_tick)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .round_req(round_req),
    .ld_en(ld_en), .ld_idx(bus_addr), .ld_data(bus_wdata), .cal(cal)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SUB:  bus_rdata = DATA_W'(subsec);
      A_SEC:  bus_rdata = {8'h00, cal.sec};
      A_MIN:  bus_rdata = {8'h00, cal.min};
      A_HOUR: bus_rdata = {8'h00, cal.hour};
      A_WDAY: bus_rdata = {8'h00, cal.wday};
      A_MDAY: bus_rdata = {8'h00, cal.mday};
      A_MON:  bus_rdata = {8'h00, cal.mon};
      A_YEAR: bus_rdata = cal.year;
      A_STAT: begin
        bus_rdata[CF_BIT]  = cf;
        bus_rdata[CIE_BIT] = cie;
      end
      A_RUN: begin
        bus_rdata[GO_BIT] = go;
        bus_rdata[EN_BIT] = en;
      end
      default: ;
    endcase
  end

  assign carry_irq = cf & cie;
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       round_req,
  input logic       clr_pre,
  input logic       cf,
  input logic       wr_stat,
  input logic       wdata_cf,
  input logic       run,
  input logic       ld_en,
  input logic       sub_zero,
  input logic [7:0] sec
);
  p_carry_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> cf);

  p_carry_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cf && !(wr_stat && !wdata_cf)) |=> cf);

  p_sec_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !round_req && sec == 8'h59) |=> (sec == 8'h00));

  p_round_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    round_req |=> (sec == 8'h00 && sub_zero));

  p_prescale_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pre |=> sub_zero);

  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_en && !round_req) |=> $stable(sec));
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .round_req(round_req),
  .clr_pre(clr_pre), .cf(cf), .wr_stat(wr_stat), .wdata_cf(bus_wdata[7]),
  .run(run), .ld_en(ld_en), .sub_zero(~|subsec), .sec(cal.sec)
);

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        carry_irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rtc_bcd_core #(.PRE_DIV(2), .SUB_STEPS(128)) i_rtc_bcd_core (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .carry_irq(carry_irq)
  );

  // {index, write data, expected read}
  localparam logic [35:0] VEC [8] = '{
    {4'd0, 16'h0055, 16'h0000},
    {4'd1, 16'h0037, 16'h0037},
    {4'd2, 16'h0048, 16'h0048},
    {4'd3, 16'h0015, 16'h0015},
    {4'd4, 16'h0003, 16'h0003},
    {4'd5, 16'h0027, 16'h0027},
    {4'd6, 16'h0009, 16'h0009},
    {4'd7, 16'h2031, 16'h2031}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                           input logic [15:0] y);
    bus_write(4'd1, {8'h00, s});
    bus_write(4'd2, {8'h00, m});
    bus_write(4'd3, {8'h00, h});
    bus_write(4'd4, {8'h00, w});
    bus_write(4'd5, {8'h00, d});
    bus_write(4'd6, {8'h00, mo});
    bus_write(4'd7, y);
  endtask

  // run for one seconds carry (256 cycles at PRE_DIV=2) then stop
  task automatic run_one_second;
    bus_write(4'd15, 16'h000B);
    repeat (260) @(posedge clk);
    bus_write(4'd15, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk_reg("R1 sub", 4'd0, 16'h0000);
    chk_reg("R1 sec", 4'd1, 16'h0000);
    chk_reg("R1 hour", 4'd3, 16'h0000);
    chk_reg("R1 mday", 4'd5, 16'h0001);
    chk_reg("R1 mon", 4'd6, 16'h0001);
    chk_reg("R1 year", 4'd7, 16'h2000);
    chk_reg("R1 stat", 4'd14, 16'h0000);
    chk_reg("R1 run", 4'd15, 16'h0000);
    chk("R1 irq", {15'd0, carry_irq}, 16'h0000);

    // R2 table of loads and readbacks
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][35:32], VEC[i][31:16]);
      chk_reg("R2 load", VEC[i][35:32], VEC[i][15:0]);
    end

    // R4 run without enable does not count
    bus_write(4'd15, 16'h0003);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk_reg("R4 no enable", 4'd0, 16'h0000);
    // R4 run with enable: one step per two ticks
    bus_write(4'd15, 16'h000B);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk_reg("R4 rate", 4'd0, 16'd10);

    // R3 time write ignored while running
    bus_write(4'd1, 16'h0042);
    chk_reg("R3 sec kept", 4'd1, 16'h0037);

    // R11 prescaler reset while running
    bus_write(4'd15, 16'h000B);
    chk_reg("R11 sub clr", 4'd0, 16'h0000);
    chk_reg("R11 readback", 4'd15, 16'h0009);
    bus_write(4'd15, 16'h0000);

    // R9 and R10 carry flag and interrupt
    bus_write(4'd14, 16'h0000);
    bus_write(4'd15, 16'h000B);
    repeat (260) @(posedge clk);
    @(negedge clk);
    chk_reg("R9 set", 4'd14, 16'h0080);
    chk("R10 masked", {15'd0, carry_irq}, 16'h0000);
    bus_write(4'd14, 16'h0090);
    chk_reg("R9 write1 no clear", 4'd14, 16'h0090);
    chk("R10 irq", {15'd0, carry_irq}, 16'h0001);
    bus_write(4'd14, 16'h0010);
    chk_reg("R9 clear", 4'd14, 16'h0010);
    chk("R10 irq low", {15'd0, carry_irq}, 16'h0000);
    bus_write(4'd15, 16'h0000);

    // R5 R6 R7 full cascade into a new century
    load_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 16'h2099);
    run_one_second();
    chk_reg("R5 sec", 4'd1, 16'h0000);
    chk_reg("R5 min", 4'd2, 16'h0000);
    chk_reg("R5 hour", 4'd3, 16'h0000);
    chk_reg("R6 wday", 4'd4, 16'h0000);
    chk_reg("R7 mday", 4'd5, 16'h0001);
    chk_reg("R7 mon", 4'd6, 16'h0001);
    chk_reg("R7 year", 4'd7, 16'h2100);

    // R7 thirty-day month, R6 weekday step
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 16'h2031);
    run_one_second();
    chk_reg("R7 apr end", 4'd5, 16'h0001);
    chk_reg("R7 may", 4'd6, 16'h0005);
    chk_reg("R6 wday inc", 4'd4, 16'h0003);

    // R8 leap and common Februaries
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 16'h2024);
    run_one_second();
    chk_reg("R8 leap day", 4'd5, 16'h0029);
    chk_reg("R8 leap mon", 4'd6, 16'h0002);
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 16'h2023);
    run_one_second();
    chk_reg("R8 common day", 4'd5, 16'h0001);
    chk_reg("R8 common mon", 4'd6, 16'h0003);

    // R12 rounding down
    load_time(8'h29, 8'h10, 8'h05, 8'h01, 8'h10, 8'h03, 16'h2030);
    bus_write(4'd14, 16'h0000);
    bus_write(4'd15, 16'h0004);
    chk_reg("R12 down sec", 4'd1, 16'h0000);
    chk_reg("R12 down min", 4'd2, 16'h0010);
    chk_reg("R12 selfclear", 4'd15, 16'h0000);
    chk_reg("R12 carry", 4'd14, 16'h0080);
    // R12 rounding up at the 30 boundary with cascade
    load_time(8'h30, 8'h59, 8'h05, 8'h01, 8'h10, 8'h03, 16'h2030);
    bus_write(4'd15, 16'h0004);
    chk_reg("R12 up sec", 4'd1, 16'h0000);
    chk_reg("R12 up min", 4'd2, 16'h0000);
    chk_reg("R12 up hour", 4'd3, 16'h0006);
    chk_reg("R12 sub", 4'd0, 16'h0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule